// File: doc/BRIEF.md
# Card Socket Status and Change-Interrupt Unit

This block is the socket-monitoring part of a removable-card host adapter. Host software reaches it through two byte ports. A write to the index port selects a register. A later read or write on the data port reaches the selected register. The index byte chooses a controller instance (bit 7), a socket (bit 6) and a register within that socket (bits 5:0).

For each socket, the block samples the card-detect pair, the battery/voltage-detect pair, write-protect, ready and power inputs through a two-flop synchronizer. The synchronized values appear in a live status register. A change of the card-detect pair, or a battery condition getting worse, sets a bit in a change register. That bit stays set until software reads the change register.

A configuration register holds a per-source enable and a 4-bit interrupt line number. Each socket drives an interrupt request, which is the OR of its pending change bits whose enable is set. The line number is presented beside the request, so the surrounding system can route it.

Top module: `sockstat_top`

## Requirements
- R1: A write with `host_port`=0 stores `host_wdata` as the index byte. A read with `host_port`=0 returns that byte on `host_rdata` after the read cycle. Reset clears the index to 0x00.
- R2: Register 0x00 is read-only. It reads as 0x80 ORed with the 4-bit revision parameter, which is 0x82 by default.
- R3: Register 0x01 reads {0, power, ready, write-protect, card-detect[1:0], battery[1:0]} in bits 7..0. An input change is visible in a read issued three clock edges after the change.
- R4: Bit 3 of register 0x04 is set whenever the synchronized card-detect pair differs from its value one cycle earlier. No bit is set while the pair stays the same.
- R5: Bit 1 of register 0x04 is set when the synchronized battery pair enters 2'b10 (warning) from any other value. Bit 0 is set when battery bit 1 falls from 1 to 0 (dead). Other battery transitions set nothing.
- R6: A data-port read of register 0x04 returns the pending bits and clears them in the same access. An event latched in that same cycle stays pending for the next read. Bits 7:4 and 2 read 0.
- R7: Register 0x05 stores the line number in bits 7:4, the card-change enable in bit 3, the warning enable in bit 1 and the dead enable in bit 0. Bit 2 reads 0. The line number also appears on that socket's `irq_line`.
- R8: `irq_req` of a socket is 1 exactly when a pending change bit of that socket has its enable set. Reading the change register drops it.
- R9: Index bit 6 selects socket 0 or 1, and the sockets are independent. An index whose bit 7 differs from the instance parameter makes data reads return 0x00 and data writes have no effect.
- R10: After reset, all change bits and configuration registers are 0 and every `irq_req` is 0.
- R11: Data reads of any other register offset return 0x00. Writes to registers 0x00, 0x01, 0x04 and to unassigned offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_port | input | 1 | 0 selects the index port, 1 selects the data port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered on the read cycle and held |
| sock_cd | input | 2*NUM_SOCK | Card-detect pairs, two bits per socket |
| sock_bvd | input | 2*NUM_SOCK | Battery/voltage-detect pairs, two bits per socket |
| sock_wp | input | NUM_SOCK | Write-protect per socket |
| sock_rdy | input | NUM_SOCK | Ready/busy per socket |
| sock_pwr | input | NUM_SOCK | Socket-powered per socket |
| irq_req | output | NUM_SOCK | Interrupt request per socket |
| irq_line | output | 4*NUM_SOCK | Interrupt line number per socket |

## Verification
A corrupt previous-value register for card-detect or battery shows up as a spurious or missing change bit. It appears in the first change-register read after the next input transition, within four cycles. An error in the clear path leaves `irq_req` high after a read, or drops a same-cycle event, so the second read gives a wrong value. A wrong index decode sends accesses to the wrong socket or instance, and that is seen as soon as the matching read-back returns.

// File: rtl/sockstat_pkg.sv
package sockstat_pkg;

    localparam logic [5:0] OFS_ID   = 6'h00;
    localparam logic [5:0] OFS_STAT = 6'h01;
    localparam logic [5:0] OFS_CHG  = 6'h04;
    localparam logic [5:0] OFS_CFG  = 6'h05;

    localparam int STAT_W = 7;

    // synchronized socket inputs, bit order matches status register bits 6..0
    typedef struct packed {
        logic       pwr;
        logic       rdy;
        logic       wp;
        logic [1:0] cd;
        logic [1:0] bvd;
    } sock_status_t;

    typedef struct packed {
        logic cd;
        logic warn;
        logic dead;
    } chg_t;

    typedef struct packed {
        logic [3:0] line;
        logic       cd_en;
        logic       warn_en;
        logic       dead_en;
    } cfg_t;

    function automatic logic [7:0] pack_chg(input chg_t c);
        return {4'b0000, c.cd, 1'b0, c.warn, c.dead};
    endfunction

    function automatic logic [7:0] pack_cfg(input cfg_t c);
        return {c.line, c.cd_en, 1'b0, c.warn_en, c.dead_en};
    endfunction

    function automatic cfg_t unpack_cfg(input logic [7:0] b);
        cfg_t c;
        c.line    = b[7:4];
        c.cd_en   = b[3];
        c.warn_en = b[1];
        c.dead_en = b[0];
        return c;
    endfunction

endpackage

// File: rtl/sockstat_sync.sv
module sockstat_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw;
            stage2_q <= stage1_q;
        end
    end

    assign synced = stage2_q;
endmodule

// File: rtl/sockstat_event.sv
module sockstat_event
    import sockstat_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  sock_status_t stat,
    input  logic         clr_chg,
    input  logic         cfg_we,
    input  cfg_t         cfg_wdata,
    output chg_t         chg_q,
    output cfg_t         cfg_q,
    output logic         irq_req,
    output logic [3:0]   irq_line
);
    logic [1:0] prev_cd_q;
    logic [1:0] prev_bvd_q;
    logic       evt_cd;
    logic       evt_warn;
    logic       evt_dead;
    chg_t       chg_kept;
    chg_t       chg_d;

    assign evt_cd   = (stat.cd != prev_cd_q);
    assign evt_warn = (stat.bvd == 2'b10) && (prev_bvd_q != 2'b10);
    assign evt_dead = !stat.bvd[1] && prev_bvd_q[1];

    always_comb begin
        chg_kept   = clr_chg ? chg_t'('0) : chg_q;
        chg_d.cd   = chg_kept.cd   | evt_cd;
        chg_d.warn = chg_kept.warn | evt_warn;
        chg_d.dead = chg_kept.dead | evt_dead;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_cd_q  <= 2'b00;
            prev_bvd_q <= 2'b00;
            chg_q      <= '0;
            cfg_q      <= '0;
        end else begin
            prev_cd_q  <= stat.cd;
            prev_bvd_q <= stat.bvd;
            chg_q      <= chg_d;
            if (cfg_we) begin
                cfg_q <= cfg_wdata;
            end
        end
    end

    assign irq_req  = (chg_q.cd & cfg_q.cd_en) | (chg_q.warn & cfg_q.warn_en)
                    | (chg_q.dead & cfg_q.dead_en);
    assign irq_line = cfg_q.line;

    assert_cd_rise_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(chg_q.cd) |-> $past(evt_cd));

    assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_chg && !evt_cd && !evt_warn && !evt_dead) |=> (chg_q == '0));

    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q));

    assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (chg_q != '0));
endmodule

// File: rtl/sockstat_top.sv
module sockstat_top
    import sockstat_pkg::*;
#(
    parameter int         NUM_SOCK = 2,
    parameter logic       INST_ID  = 1'b0,
    parameter logic [3:0] REV      = 4'h2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic                  host_port,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            host_rdata,
    input  logic [2*NUM_SOCK-1:0] sock_cd,
    input  logic [2*NUM_SOCK-1:0] sock_bvd,
    input  logic [NUM_SOCK-1:0]   sock_wp,
    input  logic [NUM_SOCK-1:0]   sock_rdy,
    input  logic [NUM_SOCK-1:0]   sock_pwr,
    output logic [NUM_SOCK-1:0]   irq_req,
    output logic [4*NUM_SOCK-1:0] irq_line
);
    localparam logic [7:0] ID_VAL = {4'h8, REV};

    logic [7:0]   index_q;
    logic [7:0]   rdata_q;
    logic [7:0]   rd_mux;
    logic         inst_hit;
    logic         sock_sel;
    logic [5:0]   reg_ofs;
    logic         sock_ok;
    logic         dat_rd;
    logic         dat_wr;
    cfg_t         cfg_in;

    sock_status_t stat_s [NUM_SOCK];
    chg_t         chg_s  [NUM_SOCK];
    cfg_t         cfg_s  [NUM_SOCK];

    assign inst_hit = (index_q[7] == INST_ID);
    assign sock_sel = index_q[6];
    assign reg_ofs  = index_q[5:0];
    assign sock_ok  = inst_hit && (int'(sock_sel) < NUM_SOCK);
    assign dat_rd   = host_rd && host_port;
    assign dat_wr   = host_wr && host_port;
    assign cfg_in   = unpack_cfg(host_wdata);

    generate
        for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
            logic [STAT_W-1:0] raw_bits;
            logic [STAT_W-1:0] sync_bits;
            logic              hit_s;

            assign raw_bits = {sock_pwr[s], sock_rdy[s], sock_wp[s],
                               sock_cd[2*s +: 2], sock_bvd[2*s +: 2]};
            assign hit_s    = sock_ok && (int'(sock_sel) == s);

            sockstat_sync #(.W(STAT_W)) u_sync (
                .clk    (clk),
                .rst    (rst),
                .raw    (raw_bits),
                .synced (sync_bits)
            );

            assign stat_s[s] = sock_status_t'(sync_bits);

            sockstat_event u_evt (
                .clk       (clk),
                .rst       (rst),
                .stat      (stat_s[s]),
                .clr_chg   (dat_rd && hit_s && (reg_ofs == OFS_CHG)),
                .cfg_we    (dat_wr && hit_s && (reg_ofs == OFS_CFG)),
                .cfg_wdata (cfg_in),
                .chg_q     (chg_s[s]),
                .cfg_q     (cfg_s[s]),
                .irq_req   (irq_req[s]),
                .irq_line  (irq_line[4*s +: 4])
            );
        end
    endgenerate

    always_comb begin
        rd_mux = 8'h00;
        if (!host_port) begin
            rd_mux = index_q;
        end else if (sock_ok) begin
            for (int s = 0; s < NUM_SOCK; s++) begin
                if (int'(sock_sel) == s) begin
                    case (reg_ofs)
                        OFS_ID:   rd_mux = ID_VAL;
                        OFS_STAT: rd_mux = {1'b0, stat_s[s]};
                        OFS_CHG:  rd_mux = pack_chg(chg_s[s]);
                        OFS_CFG:  rd_mux = pack_cfg(cfg_s[s]);
                        default:  rd_mux = 8'h00;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= 8'h00;
            rdata_q <= 8'h00;
        end else begin
            if (host_wr && !host_port) begin
                index_q <= host_wdata;
            end
            if (host_rd) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign host_rdata = rdata_q;

    assert_index_capture_R1: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_port) |=> (index_q == $past(host_wdata)));

    assert_foreign_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_port && !inst_hit) |=> (host_rdata == 8'h00));
endmodule

// File: tb/sockstat_top_test.sv
module sockstat_top_test;
    localparam int NS = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic          host_port = 1'b0;
    logic [7:0]    host_wdata = 8'h00;
    logic [7:0]    host_rdata;
    logic [2*NS-1:0] sock_cd = '0;
    logic [2*NS-1:0] sock_bvd = '0;
    logic [NS-1:0] sock_wp = '0;
    logic [NS-1:0] sock_rdy = '0;
    logic [NS-1:0] sock_pwr = '0;
    logic [NS-1:0] irq_req;
    logic [4*NS-1:0] irq_line;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    sockstat_top #(.NUM_SOCK(NS), .INST_ID(1'b0), .REV(4'h2)) uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_port(host_port), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sock_cd(sock_cd), .sock_bvd(sock_bvd), .sock_wp(sock_wp),
        .sock_rdy(sock_rdy), .sock_pwr(sock_pwr),
        .irq_req(irq_req), .irq_line(irq_line)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic port, input logic [7:0] v);
        @(negedge clk);
        host_port = port; host_wdata = v; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic port, output logic [7:0] v);
        @(negedge clk);
        host_port = port; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic set_sock(input int s, input logic [6:0] v);
        sock_bvd[2*s +: 2] = v[1:0];
        sock_cd[2*s +: 2]  = v[3:2];
        sock_wp[s]  = v[4];
        sock_rdy[s] = v[5];
        sock_pwr[s] = v[6];
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();

        // R10 / R1 reset state
        rd(1'b0, rv); check("R1 index reset", rv, 8'h00);
        check("R10 irq reset", {6'b0, irq_req}, 8'h00);
        for (int s = 0; s < NS; s++) begin
            wr(1'b0, {1'b0, s[0], 6'h04}); rd(1'b1, rv); check("R10 chg reset", rv, 8'h00);
            wr(1'b0, {1'b0, s[0], 6'h05}); rd(1'b1, rv); check("R10 cfg reset", rv, 8'h00);
        end

        // R1 index read-back
        wr(1'b0, 8'hA5); rd(1'b0, rv); check("R1 index readback", rv, 8'hA5);

        // R2 ID register, both sockets; R11 write ignored
        for (int s = 0; s < NS; s++) begin
            wr(1'b0, {1'b0, s[0], 6'h00});
            wr(1'b1, 8'h00);
            rd(1'b1, rv); check("R2 id", rv, 8'h82);
        end

        // R3 status sweep for each socket
        for (int s = 0; s < NS; s++) begin
            wr(1'b0, {1'b0, s[0], 6'h01});
            for (int v = 0; v < 128; v++) begin
                set_sock(s, v[6:0]);
                repeat (3) @(negedge clk);
                rd(1'b1, rv); check("R3 status", rv, {1'b0, v[6:0]});
            end
            wr(1'b1, 8'h00);
            rd(1'b1, rv); check("R11 status write ignored", rv, 8'h7F);
            wr(1'b0, {1'b0, s[0], 6'h04}); rd(1'b1, rv);
            rd(1'b1, rv); check("R6 cleared after read", rv, 8'h00);
        end

        // R7 cfg sweep on socket 0, line on irq_line
        wr(1'b0, 8'h05);
        for (int v = 0; v < 256; v++) begin
            wr(1'b1, v[7:0]);
            rd(1'b1, rv); check("R7 cfg readback", rv, v[7:0] & 8'hFB);
            check("R7 irq_line", {4'h0, irq_line[3:0]}, {4'h0, v[7:4]});
        end
        wr(1'b1, 8'h00);

        // R4 card-detect change on socket 0 (state cd=11 bvd=11)
        wr(1'b0, 8'h04);
        sock_cd[1:0] = 2'b00; settle();
        rd(1'b1, rv); check("R4 cd change", rv, 8'h08);
        settle();
        rd(1'b1, rv); check("R4 no change when stable", rv, 8'h00);
        sock_cd[1:0] = 2'b10; settle();
        rd(1'b1, rv); check("R4 single bit change", rv, 8'h08);

        // R6 same-cycle event survives the clearing read
        @(negedge clk); sock_cd[1:0] = 2'b11;
        @(negedge clk);
        rd(1'b1, rv); check("R6 read before event", rv, 8'h00);
        rd(1'b1, rv); check("R6 event kept", rv, 8'h08);
        rd(1'b1, rv); check("R6 cleared", rv, 8'h00);

        // R5 battery transitions (bvd currently 11)
        sock_bvd[1:0] = 2'b10; settle();
        rd(1'b1, rv); check("R5 warn", rv, 8'h02);
        sock_bvd[1:0] = 2'b00; settle();
        rd(1'b1, rv); check("R5 dead", rv, 8'h01);
        sock_bvd[1:0] = 2'b01; settle();
        rd(1'b1, rv); check("R5 no event 00->01", rv, 8'h00);
        sock_bvd[1:0] = 2'b11; settle();
        rd(1'b1, rv); check("R5 no event to good", rv, 8'h00);
        sock_bvd[1:0] = 2'b10; settle();
        sock_bvd[1:0] = 2'b01; settle();
        rd(1'b1, rv); check("R5 warn then dead", rv, 8'h03);

        // R11 writes to change reg and unassigned offsets ignored
        wr(1'b1, 8'hFF);
        rd(1'b1, rv); check("R11 chg write ignored", rv, 8'h00);
        wr(1'b0, 8'h02); wr(1'b1, 8'hFF);
        rd(1'b1, rv); check("R11 unassigned reads 0", rv, 8'h00);

        // R8 / R9 socket 1 interrupt, socket 0 untouched
        wr(1'b0, 8'h45); wr(1'b1, 8'h38);
        check("R7 irq_line s1", {4'h0, irq_line[7:4]}, 8'h03);
        sock_cd[3:2] = 2'b01; settle();
        check("R8 irq s1 set", {6'b0, irq_req}, 8'h02);
        wr(1'b0, 8'h05); rd(1'b1, rv); check("R9 socket0 cfg independent", rv, 8'h00);
        wr(1'b0, 8'h44); rd(1'b1, rv); check("R9 s1 chg", rv, 8'h08);
        check("R8 irq drops on read", {6'b0, irq_req}, 8'h00);

        // R8 enable gating: warn pending, only cd enabled
        sock_bvd[3:2] = 2'b10; settle();
        check("R8 disabled source no irq", {6'b0, irq_req}, 8'h00);
        wr(1'b0, 8'h45); wr(1'b1, 8'h3A);
        check("R8 enabled source irq", {6'b0, irq_req}, 8'h02);
        wr(1'b0, 8'h44); rd(1'b1, rv); check("R8 warn pending", rv, 8'h02);
        check("R8 irq cleared", {6'b0, irq_req}, 8'h00);

        // R9 foreign instance
        wr(1'b0, 8'h85); wr(1'b1, 8'hFF);
        rd(1'b1, rv); check("R9 foreign read zero", rv, 8'h00);
        wr(1'b0, 8'h80); rd(1'b1, rv); check("R9 foreign id zero", rv, 8'h00);
        wr(1'b0, 8'h05); rd(1'b1, rv); check("R9 foreign write ignored", rv, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule